// File: doc/BRIEF.md
# Instruction/Unified TLB Replacement State Controller

This block keeps the replacement bookkeeping for a translation unit that has a four-way fully associative instruction TLB and a 64-entry unified TLB. It does not store any translations. For the instruction TLB it keeps a 6-bit pairwise least-recently-used code, which records, for each of the six pairs of ways, which way of the pair was used more recently. Each use of a way, whether a lookup hit or a refill into that way, sets and clears a fixed group of bits. The way that should be refilled next is decoded from this code.

For the unified TLB the block keeps a 6-bit rotating replacement counter that advances on every unified TLB access. A 6-bit boundary can make it wrap before it reaches its natural end. Software can load the LRU code, the counter and the boundary through a 32-bit control-word write. A software write overrides any hardware update that arrives in the same cycle.

Top module: `tlb_repl_ctrl`

## Requirements
- R1: After reset the LRU code, the counter and the boundary are all zero. As a result `victim_idx` is 3, `lru_bad` is 0 and `urc_value` is 0.
- R2: A use of way w (`use_valid`=1, `use_idx`=w) changes the LRU code, written here as bits L5..L0, as follows. Way 0 clears L5, L4 and L3. Way 1 sets L5 and clears L2 and L1. Way 2 sets L4 and L2 and clears L0. Way 3 sets L3, L1 and L0. A hit and a refill of a way apply the same update.
- R3: The victim is decoded from the LRU code. It is way 0 when L5, L4 and L3 are all 1. It is way 1 when L5=0 and L2 and L1 are both 1. It is way 2 when L4=0, L2=0 and L0=1. It is way 3 when L3, L1 and L0 are all 0. The four patterns are mutually exclusive.
- R4: If the LRU code matches none of the four patterns, `lru_bad` is 1 and `victim_idx` is 0.
- R5: Each cycle with `utlb_access`=1 advances the counter by one, unless it wraps.
- R6: When the boundary is nonzero and the incremented counter would exceed it, the counter becomes 0. This also holds when the counter already lies beyond the boundary.
- R7: When the boundary is zero, the counter wraps from 63 to 0.
- R8: A write (`wr_en`=1) loads the LRU code from `wr_data[31:26]` (L5 is bit 31), the boundary from `wr_data[23:18]` and the counter from `wr_data[15:10]`. All other bits of `wr_data` have no effect.
- R9: A write takes priority over `use_valid` and `utlb_access` in the same cycle. Those strobes are then ignored.
- R10: With no strobe asserted, the state holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| use_valid | input | 1 | An instruction TLB way was hit or refilled |
| use_idx | input | 2 | Way that was used |
| utlb_access | input | 1 | A unified TLB access took place |
| wr_en | input | 1 | Software write of the control word |
| wr_data | input | 32 | Control word written by software |
| victim_idx | output | 2 | Instruction TLB way to refill next |
| lru_bad | output | 1 | LRU code matches no victim pattern |
| urc_value | output | 6 | Current replacement counter |

## Verification
All state is registered at the clock edge where a strobe is sampled. The outputs are then decoded combinationally from that state, so every result is due exactly one cycle after its stimulus. The bench drives its inputs on the falling edge and checks the outputs on the next falling edge, after the single rising edge that registers the stimulus. The use-sequence table holds the expected victim after each step. Directed cases cover the counter wraps, the write override and the inconsistent LRU code.

// File: rtl/tlb_repl_pkg.sv
package tlb_repl_pkg;

    localparam int WAYS     = 4;
    localparam int IDX_W    = $clog2(WAYS);
    localparam int LRU_W    = 6;
    localparam int CNT_W    = 6;
    localparam int WORD_W   = 32;
    localparam int LRU_LSB  = 26;
    localparam int BND_LSB  = 18;
    localparam int CNT_LSB  = 10;

    typedef logic [LRU_W-1:0] lru_t;
    typedef logic [CNT_W-1:0] cnt_t;
    typedef logic [IDX_W-1:0] way_t;

    typedef struct packed {
        lru_t lru;
        cnt_t bnd;
        cnt_t cnt;
    } sw_fields_t;

    function automatic sw_fields_t unpack_word(input logic [WORD_W-1:0] w);
        sw_fields_t f;
        f.lru = w[LRU_LSB +: LRU_W];
        f.bnd = w[BND_LSB +: CNT_W];
        f.cnt = w[CNT_LSB +: CNT_W];
        return f;
    endfunction

    // bits forced high when a way is used
    function automatic lru_t use_set(input int w);
        case (w)
            1:       return 6'b100000;
            2:       return 6'b010100;
            3:       return 6'b001011;
            default: return 6'b000000;
        endcase
    endfunction

    // bits forced low when a way is used
    function automatic lru_t use_clr(input int w);
        case (w)
            0:       return 6'b111000;
            1:       return 6'b000110;
            2:       return 6'b000001;
            default: return 6'b000000;
        endcase
    endfunction

    // bits examined when testing a way as victim
    function automatic lru_t vic_care(input int w);
        case (w)
            0:       return 6'b111000;
            1:       return 6'b100110;
            2:       return 6'b010101;
            default: return 6'b001011;
        endcase
    endfunction

    // required values of the examined bits
    function automatic lru_t vic_want(input int w);
        case (w)
            0:       return 6'b111000;
            1:       return 6'b000110;
            2:       return 6'b000001;
            default: return 6'b000000;
        endcase
    endfunction

endpackage

// File: rtl/tlb_lru_track.sv
module tlb_lru_track
    import tlb_repl_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  lru_t load_val,
    input  logic use_valid,
    input  way_t use_idx,
    output lru_t lru_q
);
    lru_t set_tab [WAYS];
    lru_t clr_tab [WAYS];

    for (genvar g = 0; g < WAYS; g++) begin : g_tab
        assign set_tab[g] = use_set(g);
        assign clr_tab[g] = use_clr(g);
    end

    lru_t lru_upd;
    assign lru_upd = (lru_q & ~clr_tab[use_idx]) | set_tab[use_idx];

    always_ff @(posedge clk) begin
        if (rst)            lru_q <= '0;
        else if (load)      lru_q <= load_val;
        else if (use_valid) lru_q <= lru_upd;
    end
endmodule

// File: rtl/tlb_victim_dec.sv
module tlb_victim_dec
    import tlb_repl_pkg::*;
(
    input  lru_t lru,
    output way_t victim,
    output logic bad
);
    logic [WAYS-1:0] hit;

    for (genvar g = 0; g < WAYS; g++) begin : g_match
        assign hit[g] = ((lru & vic_care(g)) == vic_want(g));
    end

    always_comb begin
        victim = '0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (hit[i]) victim = way_t'(i);
        end
        bad = (hit == '0);
    end
endmodule

// File: rtl/tlb_urc_ctr.sv
module tlb_urc_ctr
    import tlb_repl_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  cnt_t load_cnt,
    input  cnt_t load_bnd,
    input  logic step,
    output cnt_t cnt_q,
    output cnt_t bnd_q
);
    logic [CNT_W:0] inc;
    logic           wrap;

    always_comb begin
        inc  = {1'b0, cnt_q} + 1'b1;
        wrap = inc[CNT_W] || ((bnd_q != '0) && (inc > {1'b0, bnd_q}));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            bnd_q <= '0;
        end else if (load) begin
            cnt_q <= load_cnt;
            bnd_q <= load_bnd;
        end else if (step) begin
            cnt_q <= wrap ? '0 : inc[CNT_W-1:0];
        end
    end
endmodule

// File: rtl/tlb_repl_ctrl.sv
module tlb_repl_ctrl
    import tlb_repl_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        use_valid,
    input  logic [1:0]  use_idx,
    input  logic        utlb_access,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    output logic [1:0]  victim_idx,
    output logic        lru_bad,
    output logic [5:0]  urc_value
);
    sw_fields_t sw;
    lru_t       lru_q;
    cnt_t       urb_q;

    assign sw = unpack_word(wr_data);

    tlb_lru_track u_lru (
        .clk       (clk),
        .rst       (rst),
        .load      (wr_en),
        .load_val  (sw.lru),
        .use_valid (use_valid),
        .use_idx   (use_idx),
        .lru_q     (lru_q)
    );

    tlb_victim_dec u_vic (
        .lru    (lru_q),
        .victim (victim_idx),
        .bad    (lru_bad)
    );

    tlb_urc_ctr u_urc (
        .clk      (clk),
        .rst      (rst),
        .load     (wr_en),
        .load_cnt (sw.cnt),
        .load_bnd (sw.bnd),
        .step     (utlb_access),
        .cnt_q    (urc_value),
        .bnd_q    (urb_q)
    );
endmodule

// File: rtl/tlb_repl_chk.sv
module tlb_repl_chk (
    input logic        clk,
    input logic        rst,
    input logic        use_valid,
    input logic [1:0]  use_idx,
    input logic        utlb_access,
    input logic        wr_en,
    input logic [31:0] wr_data,
    input logic [1:0]  victim_idx,
    input logic        lru_bad,
    input logic [5:0]  urc_value,
    input logic [5:0]  lru_q,
    input logic [5:0]  urb_q
);
    AST_RESET_STATE: assert property (@(posedge clk) rst |=> (urc_value == 6'd0 && victim_idx == 2'd3 && !lru_bad)); // R1

    AST_WAY0_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && use_valid && use_idx == 2'd0) |=> (lru_q[5:3] == 3'b000)); // R2

    AST_WAY3_SETS: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && use_valid && use_idx == 2'd3) |=> (lru_q[3] && lru_q[1] && lru_q[0])); // R2

    AST_BAD_PICKS_ZERO: assert property (@(posedge clk) disable iff (rst)
        lru_bad |-> (victim_idx == 2'd0)); // R4

    AST_URC_STEP: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && utlb_access && urc_value != 6'd63 && (urb_q == 6'd0 || urc_value < urb_q))
        |=> (urc_value == $past(urc_value) + 6'd1)); // R5

    AST_URC_BOUND_WRAP: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && utlb_access && urb_q != 6'd0 && urc_value >= urb_q) |=> (urc_value == 6'd0)); // R6

    AST_URC_TOP_WRAP: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && utlb_access && urc_value == 6'd63) |=> (urc_value == 6'd0)); // R7

    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (urc_value == $past(wr_data[15:10]) && lru_q == $past(wr_data[31:26]))); // R9

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && !utlb_access && !use_valid) |=> ($stable(urc_value) && $stable(lru_q))); // R10
endmodule

bind tlb_repl_ctrl tlb_repl_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .use_valid   (use_valid),
    .use_idx     (use_idx),
    .utlb_access (utlb_access),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .victim_idx  (victim_idx),
    .lru_bad     (lru_bad),
    .urc_value   (urc_value),
    .lru_q       (lru_q),
    .urb_q       (urb_q)
);

// File: tb/tlb_repl_ctrl_test.sv
module tlb_repl_ctrl_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        use_valid;
    logic [1:0]  use_idx;
    logic        utlb_access;
    logic        wr_en;
    logic [31:0] wr_data;
    logic [1:0]  victim_idx;
    logic        lru_bad;
    logic [5:0]  urc_value;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    tlb_repl_ctrl uut (
        .clk(clk), .rst(rst), .use_valid(use_valid), .use_idx(use_idx),
        .utlb_access(utlb_access), .wr_en(wr_en), .wr_data(wr_data),
        .victim_idx(victim_idx), .lru_bad(lru_bad), .urc_value(urc_value)
    );

    // {way used, expected victim afterwards}, starting from reset state
    localparam logic [3:0] USE_SEQ [12] = '{
        {2'd3, 2'd2}, {2'd2, 2'd1}, {2'd1, 2'd0}, {2'd0, 2'd3},
        {2'd0, 2'd3}, {2'd1, 2'd3}, {2'd2, 2'd3}, {2'd3, 2'd0},
        {2'd0, 2'd1}, {2'd1, 2'd2}, {2'd2, 2'd3}, {2'd3, 2'd0}
    };

    task automatic check(input int act, input int exp, input string req);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        use_valid = 0; use_idx = 0; utlb_access = 0; wr_en = 0; wr_data = 0;
    endtask

    // apply inputs for one rising edge; return at the following falling edge
    task automatic cycle(input bit u, input logic [1:0] ui, input bit acc,
                         input bit we, input logic [31:0] wd);
        use_valid = u; use_idx = ui; utlb_access = acc; wr_en = we; wr_data = wd;
        @(negedge clk);
        idle_inputs();
    endtask

    function automatic logic [31:0] word(input logic [5:0] lru, input logic [5:0] bnd,
                                         input logic [5:0] cnt);
        return {lru, 2'b00, bnd, 2'b00, cnt, 10'd0};
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000 && !finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        rst = 1'b1;
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(victim_idx, 3, "R1 victim");
        check(lru_bad, 0, "R1 bad");
        check(urc_value, 0, "R1 counter");

        // R2 / R3: table walk of way uses
        for (int i = 0; i < 12; i++) begin
            cycle(1, USE_SEQ[i][3:2], 0, 0, 0);
            check(victim_idx, USE_SEQ[i][1:0], $sformatf("R2 R3 step %0d", i));
            check(lru_bad, 0, "R3 consistent");
        end

        // R10: idle cycles keep state
        cycle(0, 0, 0, 0, 0);
        cycle(0, 0, 0, 0, 0);
        check(victim_idx, 0, "R10 victim held");
        check(urc_value, 0, "R10 counter held");

        // R4: inconsistent code
        cycle(0, 0, 0, 1, word(6'b010010, 0, 0));
        check(lru_bad, 1, "R4 bad flag");
        check(victim_idx, 0, "R4 victim");
        // recover by using way 1: 110000 -> victim 3
        cycle(1, 2'd1, 0, 0, 0);
        check(lru_bad, 0, "R4 recovered");
        check(victim_idx, 3, "R2 after recovery");

        // R3: each pattern loaded directly
        cycle(0, 0, 0, 1, word(6'b011110, 0, 0));
        check(victim_idx, 1, "R3 way1 pattern");
        cycle(0, 0, 0, 1, word(6'b000001, 0, 0));
        check(victim_idx, 2, "R3 way2 pattern");

        // R5 / R6: boundary 3
        cycle(0, 0, 0, 1, word(0, 6'd3, 6'd0));
        check(urc_value, 0, "R8 counter load");
        cycle(0, 0, 1, 0, 0); check(urc_value, 1, "R5 step 1");
        cycle(0, 0, 1, 0, 0); check(urc_value, 2, "R5 step 2");
        cycle(0, 0, 1, 0, 0); check(urc_value, 3, "R5 reach boundary");
        cycle(0, 0, 1, 0, 0); check(urc_value, 0, "R6 wrap at boundary");

        // R6: counter beyond boundary
        cycle(0, 0, 0, 1, word(0, 6'd5, 6'd62));
        check(urc_value, 62, "R8 counter load 62");
        cycle(0, 0, 1, 0, 0); check(urc_value, 0, "R6 beyond boundary");

        // R7: no boundary, wrap at 63
        cycle(0, 0, 0, 1, word(0, 6'd0, 6'd62));
        cycle(0, 0, 1, 0, 0); check(urc_value, 63, "R7 reach 63");
        cycle(0, 0, 1, 0, 0); check(urc_value, 0, "R7 wrap from 63");

        // R9: write wins over use and access
        cycle(1, 2'd0, 1, 1, word(6'b111111, 6'd0, 6'd10));
        check(urc_value, 10, "R9 counter from write");
        check(victim_idx, 0, "R9 lru from write");

        // R8: non-field bits ignored
        cycle(0, 0, 0, 1, 32'h0303_03FF);
        check(urc_value, 0, "R8 ignored bits counter");
        check(victim_idx, 3, "R8 ignored bits lru");
        check(lru_bad, 0, "R8 ignored bits bad");
        cycle(0, 0, 1, 0, 0); cycle(0, 0, 1, 0, 0);
        check(urc_value, 2, "R8 boundary stayed zero");

        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule